// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This controller drives the enables of four supply rails, named A, B, C and D. It turns them on in a fixed order and off in the opposite order. Two comparator flags feed it: one says the monitored supply is too low, the other that it is too high. The controller turns these flags into a filtered window fault. A rail-up request and the absence of that fault together give permission to sequence.

Once permission holds, a programmable start delay runs before rail A turns on. Programmable gaps then separate the later rails. When permission is lost, the rails go down from D back to A, and the same delays set the wait before each step. Permission can change in the middle of a sequence. The controller then reverses from the rail it has reached, so the enables always form a contiguous run that begins at A.

Top module: `pwr_seq4`

## Requirements
- R1: While reset is high and in the cycle after it, `rail_en` is 0000, `fault` is 0 and `seq_status` is 00 (all off).
- R2: `fault` rises only after (`uv_flag` OR `ov_flag`) has been sampled high on FLT_SET_CYC consecutive clock edges (default 6). A shorter pulse leaves `fault` low and leaves the enables unchanged.
- R3: `fault` falls once both flags have been sampled low on FLT_CLR_CYC consecutive edges (default 3). FLT_CLR_CYC is smaller than FLT_SET_CYC.
- R4: Permission is `seq_req`=1 with `fault`=0. When all rails are off, rail A (`rail_en[0]`) rises on the (`start_dly`+1)-th clock edge after the first edge that samples permission.
- R5: Rails rise in the order A, B, C, D, on bits 0 to 3 of `rail_en`. Rail B rises `gap_ab`+1 edges after rail A, rail C rises `gap_bc`+1 edges after rail B, and rail D rises `gap_cd`+1 edges after rail C.
- R6: Loss of permission brings the rails down in the order D, C, B, A. Rail D falls on the (`gap_cd`+1)-th edge after the first edge that samples the loss. Rail C then falls `gap_bc`+1 edges later, rail B `gap_ab`+1 edges later, and rail A `start_dly`+1 edges later.
- R7: A rising `fault` with `seq_req` held high shuts the rails down exactly as a withdrawn request does. While `fault` is high, no enable rises.
- R8: `rail_en` is always a thermometer code (0000, 0001, 0011, 0111, 1111), and at most one bit changes per cycle. A change of permission in the middle of a sequence reverses direction from the current rail. The delay for that next step is the gap between the current level and the neighbouring level.
- R9: Each step's delay is captured when the step starts. A change to a delay input during the step does not change that step's timing.
- R10: `seq_status` encodes 00 all off, 01 sequencing up (this includes the start wait), 10 all on and 11 sequencing down. In state 10, `rail_en` is 1111; in state 00, `rail_en` is 0000.
- R11: A delay of zero makes the step take effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_flag | input | 1 | Supply below its low limit |
| ov_flag | input | 1 | Supply above its high limit |
| seq_req | input | 1 | Request to bring rails up |
| start_dly | input | DLY_W | Delay before rail A rises; also the delay before rail A falls |
| gap_ab | input | DLY_W | Delay between rails A and B |
| gap_bc | input | DLY_W | Delay between rails B and C |
| gap_cd | input | DLY_W | Delay between rails C and D |
| rail_en | output | 4 | Rail enables; bit 0 is A, bit 3 is D |
| fault | output | 1 | Filtered window fault |
| seq_status | output | 2 | Sequencer state code |

## Verification
Power-up and power-down are run with unequal gaps, so a swapped gap or a swapped rail order shows up as a wrong edge count. A run with all delays at zero tests the one-cycle step. A fault injected into a fully powered system tells a too-short filter apart from a correct one, and a sub-threshold pulse shows that glitches are rejected. Reversals are tested at three points: during the start wait, after rail B, and after rail D falls. These show that the direction flips from the current level, with the correct neighbouring gap.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int NRAIL = 4;
    localparam int LVL_W = $clog2(NRAIL + 1);
    localparam int IDX_W = $clog2(NRAIL);

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_UP   = 2'b01,
        ST_ON   = 2'b10,
        ST_DOWN = 2'b11
    } seq_state_e;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        seq_state_e       st;
    } seq_pos_t;

    function automatic logic [IDX_W-1:0] lvl_idx(input logic [LVL_W-1:0] l);
        return l[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/pwr_flt_filter.sv
module pwr_flt_filter #(
    parameter int SET_CYC = 6,
    parameter int CLR_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic flt
);
    localparam int CW = $clog2(SET_CYC + 1);

    if (CLR_CYC < 1 || CLR_CYC >= SET_CYC) begin : g_bad_cfg
        $error("clear window must be shorter than set window");
    end

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = flt ? CW'(CLR_CYC - 1) : CW'(SET_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            flt <= 1'b0;
        end else if (raw == flt) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            flt <= raw;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_step_ctrl.sv
module pwr_step_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [DLY_W-1:0]      dly [NRAIL],
    output seq_pos_t              pos
);
    logic [DLY_W-1:0] cnt;
    logic [DLY_W-1:0] tgt;
    logic [LVL_W-1:0] lvl_inc;
    logic [LVL_W-1:0] lvl_dec;
    logic [LVL_W-1:0] lvl_dec2;
    logic             expired;

    assign lvl_inc  = pos.lvl + 1'b1;
    assign lvl_dec  = pos.lvl - 1'b1;
    assign lvl_dec2 = pos.lvl - LVL_W'(2);
    assign expired  = (cnt == tgt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos.lvl <= '0;
            pos.st  <= ST_OFF;
            cnt     <= '0;
            tgt     <= '0;
        end else begin
            case (pos.st)
                ST_OFF: begin
                    if (go) begin
                        pos.st <= ST_UP;
                        tgt    <= dly[0];
                        cnt    <= '0;
                    end
                end
                ST_UP: begin
                    if (!go) begin
                        cnt <= '0;
                        if (pos.lvl == '0) begin
                            pos.st <= ST_OFF;
                        end else begin
                            pos.st <= ST_DOWN;
                            tgt    <= dly[lvl_idx(lvl_dec)];
                        end
                    end else if (expired) begin
                        pos.lvl <= lvl_inc;
                        cnt     <= '0;
                        if (lvl_inc == LVL_W'(NRAIL)) begin
                            pos.st <= ST_ON;
                        end else begin
                            tgt <= dly[lvl_idx(lvl_inc)];
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ON: begin
                    if (!go) begin
                        pos.st <= ST_DOWN;
                        tgt    <= dly[NRAIL-1];
                        cnt    <= '0;
                    end
                end
                ST_DOWN: begin
                    if (go) begin
                        cnt <= '0;
                        if (pos.lvl == LVL_W'(NRAIL)) begin
                            pos.st <= ST_ON;
                        end else begin
                            pos.st <= ST_UP;
                            tgt    <= dly[lvl_idx(pos.lvl)];
                        end
                    end else if (expired) begin
                        pos.lvl <= lvl_dec;
                        cnt     <= '0;
                        if (lvl_dec == '0) begin
                            pos.st <= ST_OFF;
                        end else begin
                            tgt <= dly[lvl_idx(lvl_dec2)];
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: pos.st <= ST_OFF;
            endcase
        end
    end
endmodule

// File: rtl/pwr_seq4.sv
module pwr_seq4
    import pwr_seq_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int FLT_SET_CYC = 6,
    parameter int FLT_CLR_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uv_flag,
    input  logic             ov_flag,
    input  logic             seq_req,
    input  logic [DLY_W-1:0] start_dly,
    input  logic [DLY_W-1:0] gap_ab,
    input  logic [DLY_W-1:0] gap_bc,
    input  logic [DLY_W-1:0] gap_cd,
    output logic [3:0]       rail_en,
    output logic             fault,
    output logic [1:0]       seq_status
);
    logic             win_bad;
    logic             permit;
    logic [DLY_W-1:0] dly_arr [NRAIL];
    seq_pos_t         pos;

    assign win_bad    = uv_flag | ov_flag;
    assign permit     = seq_req & ~fault;
    assign dly_arr[0] = start_dly;
    assign dly_arr[1] = gap_ab;
    assign dly_arr[2] = gap_bc;
    assign dly_arr[3] = gap_cd;

    pwr_flt_filter #(
        .SET_CYC (FLT_SET_CYC),
        .CLR_CYC (FLT_CLR_CYC)
    ) u_flt (
        .clk (clk),
        .rst (rst),
        .raw (win_bad),
        .flt (fault)
    );

    pwr_step_ctrl #(
        .DLY_W (DLY_W)
    ) u_step (
        .clk (clk),
        .rst (rst),
        .go  (permit),
        .dly (dly_arr),
        .pos (pos)
    );

    for (genvar i = 0; i < NRAIL; i++) begin : g_rail
        assign rail_en[i] = (pos.lvl > LVL_W'(i));
    end

    assign seq_status = pos.st;
endmodule

// File: rtl/pwr_seq4_chk.sv
module pwr_seq4_chk (
    input logic       clk,
    input logic       rst,
    input logic       uv_flag,
    input logic       ov_flag,
    input logic       seq_req,
    input logic [3:0] rail_en,
    input logic       fault,
    input logic [1:0] seq_status
);
    p_rst_off_r1: assert property (@(posedge clk)
        rst |=> (rail_en == 4'b0000 && !fault && seq_status == 2'b00));

    p_flt_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(uv_flag | ov_flag));

    p_flt_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(fault) |-> !$past(uv_flag | ov_flag));

    p_fall_in_down_r6: assert property (@(posedge clk) disable iff (rst)
        (|($past(rail_en) & ~rail_en)) |-> ($past(seq_status) == 2'b11));

    p_no_rise_on_fault_r7: assert property (@(posedge clk) disable iff (rst)
        fault |=> ((rail_en & ~$past(rail_en)) == 4'b0000));

    p_one_step_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(rail_en ^ $past(rail_en)) <= 1);

    p_thermo_r8: assert property (@(posedge clk) disable iff (rst)
        (rail_en == 4'b0000 || rail_en == 4'b0001 || rail_en == 4'b0011 ||
         rail_en == 4'b0111 || rail_en == 4'b1111));

    p_status_on_r10: assert property (@(posedge clk) disable iff (rst)
        (seq_status == 2'b10) |-> (rail_en == 4'b1111));

    p_status_off_r10: assert property (@(posedge clk) disable iff (rst)
        (seq_status == 2'b00) |-> (rail_en == 4'b0000));

    p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (!seq_req && seq_status == 2'b10) |=> (seq_status == 2'b11));
endmodule

bind pwr_seq4 pwr_seq4_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .uv_flag    (uv_flag),
    .ov_flag    (ov_flag),
    .seq_req    (seq_req),
    .rail_en    (rail_en),
    .fault      (fault),
    .seq_status (seq_status)
);

// File: tb/sim_pwr_seq4.sv
module sim_pwr_seq4;
    localparam int DW   = 8;
    localparam int FSET = 6;
    localparam int FCLR = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          uv_flag, ov_flag, seq_req;
    logic [DW-1:0] start_dly, gap_ab, gap_bc, gap_cd;
    logic [3:0]    rail_en;
    logic          fault;
    logic [1:0]    seq_status;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pwr_seq4 #(.DLY_W(DW), .FLT_SET_CYC(FSET), .FLT_CLR_CYC(FCLR)) u0 (
        .clk(clk), .rst(rst), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .seq_req(seq_req), .start_dly(start_dly), .gap_ab(gap_ab),
        .gap_bc(gap_bc), .gap_cd(gap_cd), .rail_en(rail_en),
        .fault(fault), .seq_status(seq_status)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_chg(output int n);
        logic [3:0] prev;
        prev = rail_en;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rail_en == prev && n < 500);
    endtask

    task automatic step(input int exp_n, input logic [3:0] exp_en, input string tag);
        int n;
        wait_chg(n);
        check(n == exp_n, {tag, " delay"}, n, exp_n);
        check(rail_en == exp_en, {tag, " enables"}, rail_en, exp_en);
    endtask

    task automatic wait_status(input logic [1:0] s);
        int n;
        n = 0;
        while (seq_status != s && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic set_dly(input int d0, input int d1, input int d2, input int d3);
        start_dly = DW'(d0); gap_ab = DW'(d1); gap_bc = DW'(d2); gap_cd = DW'(d3);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(rail_en == 4'b0000 && !fault, "R1 in reset", rail_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rail_en == 4'b0000, "R1 enables after reset", rail_en, 0);
        check(seq_status == 2'b00, "R10 status off", seq_status, 0);
    endtask

    task automatic t_powerup();
        set_dly(3, 2, 5, 1);
        seq_req = 1'b1;
        step(5, 4'b0001, "R4 rail A");
        check(seq_status == 2'b01, "R10 status up", seq_status, 1);
        gap_ab = DW'(20);
        step(3, 4'b0011, "R9 rail B uses captured gap");
        gap_ab = DW'(2);
        step(6, 4'b0111, "R5 rail C");
        step(2, 4'b1111, "R5 rail D");
        check(seq_status == 2'b10, "R10 status on", seq_status, 2);
    endtask

    task automatic t_powerdown();
        seq_req = 1'b0;
        step(3, 4'b0111, "R6 rail D off");
        check(seq_status == 2'b11, "R10 status down", seq_status, 3);
        step(6, 4'b0011, "R6 rail C off");
        step(3, 4'b0001, "R6 rail B off");
        step(4, 4'b0000, "R6 rail A off");
        check(seq_status == 2'b00, "R10 status off after down", seq_status, 0);
    endtask

    task automatic t_zero();
        set_dly(0, 0, 0, 0);
        seq_req = 1'b1;
        step(2, 4'b0001, "R11 zero start");
        step(1, 4'b0011, "R11 zero gap B");
        step(1, 4'b0111, "R11 zero gap C");
        step(1, 4'b1111, "R11 zero gap D");
        seq_req = 1'b0;
        step(2, 4'b0111, "R11 zero down D");
        step(1, 4'b0011, "R11 zero down C");
        step(1, 4'b0001, "R11 zero down B");
        step(1, 4'b0000, "R11 zero down A");
    endtask

    task automatic t_fault();
        int n;
        bit ok;
        set_dly(3, 2, 5, 1);
        seq_req = 1'b1;
        wait_status(2'b10);
        uv_flag = 1'b1;
        repeat (FSET - 1) @(negedge clk);
        uv_flag = 1'b0;
        ok = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (fault || rail_en != 4'b1111) ok = 1'b0;
        end
        check(ok, "R2 short pulse ignored", rail_en, 15);
        ov_flag = 1'b1;
        n = 0;
        while (!fault && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == FSET, "R2 fault set latency", n, FSET);
        step(3, 4'b0111, "R7 fault drops rail D");
        step(6, 4'b0011, "R7 fault drops rail C");
        step(3, 4'b0001, "R7 fault drops rail B");
        step(4, 4'b0000, "R7 fault drops rail A");
        repeat (5) @(negedge clk);
        check(rail_en == 4'b0000, "R7 no rise under fault", rail_en, 0);
        ov_flag = 1'b0;
        n = 0;
        while (fault && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == FCLR, "R3 fault clear latency", n, FCLR);
        step(5, 4'b0001, "R4 restart after fault clear");
    endtask

    task automatic t_reverse();
        bit ok;
        seq_req = 1'b0;
        wait_status(2'b00);
        set_dly(4, 4, 4, 4);
        seq_req = 1'b1;
        step(6, 4'b0001, "R8 rev setup A");
        step(5, 4'b0011, "R8 rev setup B");
        seq_req = 1'b0;
        step(6, 4'b0001, "R8 reverse after B");
        check(seq_status == 2'b11, "R8 status down after reverse", seq_status, 3);
        step(5, 4'b0000, "R8 reverse to off");
        seq_req = 1'b1;
        wait_status(2'b10);
        seq_req = 1'b0;
        step(6, 4'b0111, "R8 down D");
        seq_req = 1'b1;
        step(6, 4'b1111, "R8 back up D");
        check(seq_status == 2'b10, "R8 status on again", seq_status, 2);
        seq_req = 1'b0;
        wait_status(2'b00);
        set_dly(5, 4, 4, 4);
        seq_req = 1'b1;
        @(negedge clk);
        seq_req = 1'b0;
        ok = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (rail_en != 4'b0000) ok = 1'b0;
        end
        check(ok, "R8 abort during start wait", rail_en, 0);
        check(seq_status == 2'b00, "R10 off after abort", seq_status, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        uv_flag = 1'b0;
        ov_flag = 1'b0;
        seq_req = 1'b0;
        set_dly(0, 0, 0, 0);
        t_reset();
        t_powerup();
        t_powerdown();
        t_zero();
        t_fault();
        t_reverse();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule